// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a CPU core and the pins of an external memory bus. It handles three kinds of access: program fetches, data reads and data writes. The address space is 20 bits wide. The low address byte and the data byte take turns on one shared 8-bit bus. Address bits 8 to 19 have their own pins.

Each external cycle has a fixed sequence, counted in base-clock ticks:
- An address phase, with the latch strobe high.
- A short hold phase, in which the low address stays on the bus.
- A strobe phase, using the program-read, data-read or data-write strobe.
- A tail tick, in which write data is held.

On data cycles only, a wait input stretches the strobe phase for as long as it stays high.

The CPU side is a single-outstanding request/acknowledge port. A request is accepted when `req_valid` and `req_ready` are both high. The controller then routes the request:
- A program fetch goes to internal memory only when the internal-ROM enable is high and the address lies in the lowest 64 KB.
- Every other fetch, and every data access, goes out on the bus.

During data cycles, address pins 16 to 19 carry the CPU's program-counter segment bits instead of data-address bits.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the controller is idle:
  - `ale` is low.
  - `psen_n`, `rd_n` and `wr_n` are high.
  - `ad_oe` is low and `ack` is low.
  - `req_ready` is high.
- R2: A fetch (`req_kind` 2'b00) is internal when `ea_int_en` is high and `req_addr[19:16]` is zero. An internal fetch makes no bus activity, and returns `ack` with `ack_int` high in the cycle after acceptance.
- R3: A fetch with `ea_int_en` low, or with `req_addr[19:16]` nonzero, runs an external cycle that uses `psen_n` as its strobe.
- R4: Data reads (`req_kind` 2'b01) always use `rd_n` and data writes (`req_kind` 2'b10) always use `wr_n`, whatever the state of `ea_int_en` or the address. For these accesses `ack_int` stays low.
- R5: An external cycle raises `ale` in the cycle after acceptance and holds it for exactly 2 ticks. During those ticks the low address byte is driven on `ad_out` with `ad_oe` high.
- R6: After `ale` falls, the low address stays on `ad_out` for exactly 1 tick. The strobe then goes low; without wait states it stays low for exactly 2 ticks.
- R7: `addr_hi` holds the following values:
  - `addr_hi[7:0]` carries `req_addr[15:8]`.
  - On fetches, `addr_hi[11:8]` carries `req_addr[19:16]`.
  - On data cycles, `addr_hi[11:8]` carries `req_pc_hi`.
  - `addr_hi` is stable while a strobe is low.
- R8: During `psen_n` or `rd_n` low, `ad_oe` is low. The byte on `ad_in` at the last strobe tick is returned on `rdata`, together with a one-cycle `ack` in the tick that follows the strobe.
- R9: On writes, `req_wdata` is driven on `ad_out` with `ad_oe` high while `wr_n` is low, and for one tick after `wr_n` rises.
- R10: On data cycles, `wait_in` high at the last strobe tick keeps `rd_n`/`wr_n` low for one more tick, repeating while it stays high.
- R11: `wait_in` has no effect on fetch cycles; `psen_n` stays low for exactly 2 ticks.
- R12: Only one access is outstanding at a time:
  - `req_ready` is low from acceptance until the cycle after `ack`.
  - At most one strobe is low at any time.
  - `ack` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_int_en | input | 1 | High: the lowest 64 KB of program space is internal |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write |
| req_addr | input | 20 | Access address |
| req_pc_hi | input | 4 | Program-counter segment bits, driven on the top address pins during data cycles |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| ack_int | output | 1 | The completing access was routed internally |
| rdata | output | 8 | Byte read from the bus |
| ale | output | 1 | Low-address latch strobe |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed address/data bus, outgoing value |
| ad_oe | output | 1 | Drive enable for the multiplexed bus |
| ad_in | input | 8 | Multiplexed bus, incoming value |
| addr_hi | output | 12 | Address bits 8 to 19 |
| wait_in | input | 1 | Stretch request for data cycles |

## Verification
The bench builds the controller with its default timing parameters:
- a 2-tick latch strobe
- a 1-tick address hold
- a 2-tick strobe
- a 1-tick tail

With these values every phase boundary falls only one or two ticks from its neighbour. An off-by-one in any counter reload therefore shows up directly as a wrong pulse width or gap.

The 20-bit address with a 16-bit internal boundary lets the bench place fetches on both sides of the split, under both states of the internal-ROM enable. It also drives distinct program-counter segment bits during data cycles, to show which source reaches the top address pins.

Wait states of several lengths are applied to both reads and writes, and the same held-high wait is applied to a fetch.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    XK_FETCH = 2'b00,
    XK_READ  = 2'b01,
    XK_WRITE = 2'b10
  } xk_kind_t;

  typedef enum logic [2:0] {
    XS_IDLE = 3'd0,
    XS_ADDR = 3'd1,
    XS_HOLD = 3'd2,
    XS_STRB = 3'd3,
    XS_TAIL = 3'd4,
    XS_INTL = 3'd5
  } xs_state_t;

endpackage

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int AD_W    = 8,
  parameter int SEG_LSB = 16,
  localparam int HI_W   = ADDR_W - AD_W,
  localparam int PCH_W  = ADDR_W - SEG_LSB
) (
  input  xk_kind_t          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PCH_W-1:0]  pc_hi,
  input  logic              ea_int_en,
  output logic              go_ext,
  output logic [HI_W-1:0]   hi_addr
);

  logic is_fetch;
  logic seg_zero;

  always_comb begin
    is_fetch = (kind == XK_FETCH);
    seg_zero = (addr[ADDR_W-1:SEG_LSB] == '0);
    // only program fetches in the low segment with the enable set stay inside
    go_ext   = !is_fetch || !ea_int_en || !seg_zero;
    hi_addr  = {(is_fetch ? addr[ADDR_W-1:SEG_LSB] : pc_hi),
                addr[SEG_LSB-1:AD_W]};
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ALE_T  = 2,
  parameter int HOLD_T = 1,
  parameter int STB_T  = 2,
  parameter int TAIL_T = 1,
  localparam int CNT_W = $clog2(ALE_T + HOLD_T + STB_T + TAIL_T + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_ext,
  input  logic      is_data,
  input  logic      wait_in,
  output xs_state_t state,
  output logic      cap,
  output logic      ready,
  output logic      ack,
  output logic      ack_int
);

  xs_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             stretch;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    stretch  = is_data && wait_in;
    st_d     = st_q;
    cnt_d    = cnt_zero ? cnt_q : cnt_q - 1'b1;
    cap      = 1'b0;
    unique case (st_q)
      XS_IDLE: begin
        if (start) begin
          if (start_ext) begin
            st_d  = XS_ADDR;
            cnt_d = CNT_W'(ALE_T - 1);
          end else begin
            st_d  = XS_INTL;
          end
        end
      end
      XS_ADDR: begin
        if (cnt_zero) begin
          st_d  = XS_HOLD;
          cnt_d = CNT_W'(HOLD_T - 1);
        end
      end
      XS_HOLD: begin
        if (cnt_zero) begin
          st_d  = XS_STRB;
          cnt_d = CNT_W'(STB_T - 1);
        end
      end
      XS_STRB: begin
        if (cnt_zero && !stretch) begin
          st_d  = XS_TAIL;
          cnt_d = CNT_W'(TAIL_T - 1);
          cap   = 1'b1;
        end
      end
      XS_TAIL: begin
        if (cnt_zero) st_d = XS_IDLE;
      end
      XS_INTL: st_d = XS_IDLE;
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  logic tail_first;
  logic tail_seen_q;

  // ack marks only the first tail tick so it stays one cycle for any TAIL_T
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail_seen_q <= 1'b0;
    else        tail_seen_q <= (st_q == XS_TAIL);
  end

  always_comb begin
    tail_first = (st_q == XS_TAIL) && !tail_seen_q;
    state      = st_q;
    ready      = (st_q == XS_IDLE);
    ack        = tail_first || (st_q == XS_INTL);
    ack_int    = (st_q == XS_INTL);
  end

endmodule

// File: rtl/xbus_latch.sv
module xbus_latch
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 8,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  xk_kind_t        kind_in,
  input  logic [AD_W-1:0] lo_in,
  input  logic [HI_W-1:0] hi_in,
  input  logic [AD_W-1:0] wd_in,
  input  logic            cap,
  input  logic [AD_W-1:0] ad_in,
  output xk_kind_t        kind_q,
  output logic [AD_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q,
  output logic [AD_W-1:0] wd_q,
  output logic [AD_W-1:0] rd_q
);

  logic rd_en;

  always_comb rd_en = cap && (kind_q != XK_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= XK_FETCH;
      lo_q   <= '0;
      hi_q   <= '0;
      wd_q   <= '0;
    end else if (load) begin
      kind_q <= kind_in;
      lo_q   <= lo_in;
      hi_q   <= hi_in;
      wd_q   <= wd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= ad_in;
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int AD_W    = 8,
  parameter int SEG_LSB = 16,
  parameter int ALE_T   = 2,
  parameter int HOLD_T  = 1,
  parameter int STB_T   = 2,
  parameter int TAIL_T  = 1,
  localparam int HI_W   = ADDR_W - AD_W,
  localparam int PCH_W  = ADDR_W - SEG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ea_int_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PCH_W-1:0]  req_pc_hi,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              ack,
  output logic              ack_int,
  output logic [AD_W-1:0]   rdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in,
  output logic [HI_W-1:0]   addr_hi,
  input  logic              wait_in
);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb rst_i_n = rst_sync_q[1];

  xk_kind_t        kind_in, kind_q;
  logic            go_ext;
  logic [HI_W-1:0] hi_in, hi_q;
  logic [AD_W-1:0] lo_q, wd_q;
  logic            start, cap, ready;
  xs_state_t       state;

  always_comb begin
    kind_in = xk_kind_t'(req_kind);
    start   = req_valid && ready;
  end

  xbus_route #(
    .ADDR_W (ADDR_W),
    .AD_W   (AD_W),
    .SEG_LSB(SEG_LSB)
  ) u_route (
    .kind     (kind_in),
    .addr     (req_addr),
    .pc_hi    (req_pc_hi),
    .ea_int_en(ea_int_en),
    .go_ext   (go_ext),
    .hi_addr  (hi_in)
  );

  xbus_seq #(
    .ALE_T (ALE_T),
    .HOLD_T(HOLD_T),
    .STB_T (STB_T),
    .TAIL_T(TAIL_T)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .start_ext(go_ext),
    .is_data  (kind_q != XK_FETCH),
    .wait_in  (wait_in),
    .state    (state),
    .cap      (cap),
    .ready    (ready),
    .ack      (ack),
    .ack_int  (ack_int)
  );

  xbus_latch #(
    .ADDR_W(ADDR_W),
    .AD_W  (AD_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (start),
    .kind_in(kind_in),
    .lo_in  (req_addr[AD_W-1:0]),
    .hi_in  (hi_in),
    .wd_in  (req_wdata),
    .cap    (cap),
    .ad_in  (ad_in),
    .kind_q (kind_q),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .wd_q   (wd_q),
    .rd_q   (rdata)
  );

  logic in_addr, in_strb, in_tail, is_wr;

  always_comb begin
    in_addr   = (state == XS_ADDR) || (state == XS_HOLD);
    in_strb   = (state == XS_STRB);
    in_tail   = (state == XS_TAIL);
    is_wr     = (kind_q == XK_WRITE);
    req_ready = ready;
    ale       = (state == XS_ADDR);
    psen_n    = !(in_strb && (kind_q == XK_FETCH));
    rd_n      = !(in_strb && (kind_q == XK_READ));
    wr_n      = !(in_strb && is_wr);
    ad_oe     = in_addr || (is_wr && (in_strb || in_tail));
    ad_out    = in_addr ? lo_q : wd_q;
    addr_hi   = hi_q;
  end

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int HI_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            psen_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            ack,
  input logic            ack_int,
  input logic            req_ready,
  input logic            wait_in,
  input logic [HI_W-1:0] addr_hi
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);                             // R12

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));                                     // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);                                                         // R12

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !psen_n || !rd_n || !wr_n) |-> !req_ready);                    // R12

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);                                        // R8

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);                                                      // R9

  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ack_int |-> (!ale && psen_n && rd_n && wr_n));                         // R2

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |=> (psen_n && rd_n && wr_n) || $stable(addr_hi)); // R7

  AST_RD_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n) && wait_in) |=> !rd_n);                         // R10

  AST_WR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n) && wait_in) |=> !wr_n);                         // R10

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HI_W(HI_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ale      (ale),
  .psen_n   (psen_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .ad_oe    (ad_oe),
  .ack      (ack),
  .ack_int  (ack_int),
  .req_ready(req_ready),
  .wait_in  (wait_in),
  .addr_hi  (addr_hi)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ea_int_en;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [19:0] req_addr;
  logic [3:0]  req_pc_hi;
  logic [7:0]  req_wdata;
  logic        ack, ack_int;
  logic [7:0]  rdata;
  logic        ale, psen_n, rd_n, wr_n;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [11:0] addr_hi;
  logic        wait_in;

  always #5 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ea_int_en(ea_int_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_pc_hi(req_pc_hi), .req_wdata(req_wdata),
    .ack(ack), .ack_int(ack_int), .rdata(rdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .wait_in(wait_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // external memory model: byte derived from the latched address and strobe type
  function automatic logic [7:0] mem_byte(input logic [11:0] hi, input logic [7:0] lo,
                                          input bit fetch);
    return lo ^ hi[7:0] ^ {hi[11:8], hi[11:8]} ^ (fetch ? 8'h5A : 8'hC3);
  endfunction

  logic [19:0] lat_addr;
  always @(negedge clk) if (ale) lat_addr <= {addr_hi, ad_out};

  always_comb begin
    if (!psen_n)    ad_in = mem_byte(lat_addr[19:8], lat_addr[7:0], 1'b1);
    else if (!rd_n) ad_in = mem_byte(lat_addr[19:8], lat_addr[7:0], 1'b0);
    else            ad_in = 8'hEE;
  end

  typedef struct {
    bit          ext;
    logic [1:0]  kind;
    logic [7:0]  lo;
    logic [11:0] hi;
    logic [7:0]  wd;
    logic [7:0]  rexp;
    int          slen;
    string       stag;
  } exp_t;

  exp_t q[$];

  // monitor
  bit prev_ale = 0, prev_stb = 0, in_gap = 0;
  int ale_len = 0, gap = 0, stb_len = 0;

  always @(negedge clk) begin
    bit stb;
    stb = !psen_n || !rd_n || !wr_n;
    if (rst_n) begin
      if (q.size() == 0) begin
        if (ale || stb || ack) chk(1'b0, "R12 spurious activity", {ale, stb, ack}, 0);
      end else begin
        exp_t h;
        h = q[0];
        if (ale) begin
          if (!prev_ale) begin
            chk(h.ext, "R2 bus cycle on internal fetch", 1, 0);
            chk(ad_oe && ad_out == h.lo, "R5 low address on AD", ad_out, h.lo);
            chk(addr_hi == h.hi, "R7 high address", addr_hi, h.hi);
          end
          ale_len++;
        end
        if (!ale && prev_ale) begin
          chk(ale_len == 2, "R5 ALE width", ale_len, 2);
          in_gap = 1;
          gap = 0;
        end
        if (in_gap && !ale && !stb) begin
          gap++;
          chk(ad_oe && ad_out == h.lo, "R6 low address hold", ad_out, h.lo);
        end
        if (stb && !prev_stb) begin
          chk(gap == 1, "R6 ALE-to-strobe gap", gap, 1);
          in_gap = 0;
          case (h.kind)
            2'b00: chk(!psen_n && rd_n && wr_n, "R3 fetch uses psen_n",
                       {psen_n, rd_n, wr_n}, 3'b011);
            2'b01: chk(psen_n && !rd_n && wr_n, "R4 read uses rd_n",
                       {psen_n, rd_n, wr_n}, 3'b101);
            default: chk(psen_n && rd_n && !wr_n, "R4 write uses wr_n",
                         {psen_n, rd_n, wr_n}, 3'b110);
          endcase
        end
        if (stb) begin
          stb_len++;
          if (h.kind == 2'b10) chk(ad_oe && ad_out == h.wd, "R9 write data during WR", ad_out, h.wd);
          else                 chk(!ad_oe, "R8 bus released during read strobe", ad_oe, 0);
          chk(addr_hi == h.hi, "R7 high address stable", addr_hi, h.hi);
        end
        if (!stb && prev_stb) begin
          chk(stb_len == h.slen, h.stag, stb_len, h.slen);
          if (h.kind == 2'b10) chk(ad_oe && ad_out == h.wd, "R9 write data tail", ad_out, h.wd);
        end
        if (ack) begin
          chk(ack_int == !h.ext, "R2/R4 ack_int routing", ack_int, !h.ext);
          if (h.ext && h.kind != 2'b10) chk(rdata == h.rexp, "R8 read data", rdata, h.rexp);
          void'(q.pop_front());
          ale_len = 0; stb_len = 0; gap = 0; in_gap = 0;
        end
      end
    end
    prev_ale = ale;
    prev_stb = stb;
  end

  task automatic issue(input logic [1:0] kind, input logic [19:0] addr, input logic [3:0] pch,
                       input logic [7:0] wd, input int wcnt);
    exp_t e;
    e.kind = kind;
    e.ext  = (kind != 2'b00) || !ea_int_en || (addr[19:16] != 4'h0);
    e.lo   = addr[7:0];
    e.hi   = {(kind == 2'b00) ? addr[19:16] : pch, addr[15:8]};
    e.wd   = wd;
    e.rexp = mem_byte(e.hi, e.lo, kind == 2'b00);
    e.slen = 2 + ((kind != 2'b00) ? wcnt : 0);
    e.stag = (kind == 2'b00) ? ((wcnt > 0) ? "R11 fetch ignores wait" : "R6 strobe width")
                             : ((wcnt > 0) ? "R10 wait stretch" : "R6 strobe width");
    while (!req_ready) @(negedge clk);
    q.push_back(e);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_pc_hi = pch; req_wdata = wd;
    wait_in = (wcnt > 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low while busy", req_ready, 0);
    if (wcnt > 0 && e.ext) begin
      int n;
      n = 0;
      forever begin
        if (!psen_n || !rd_n || !wr_n) n++;
        if (n == 2 + wcnt || (n > 0 && psen_n && rd_n && wr_n)) break;
        @(negedge clk);
      end
    end
    wait_in = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "R12 watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ea_int_en = 1'b1; req_valid = 1'b0; req_kind = 2'b00;
    req_addr = '0; req_pc_hi = '0; req_wdata = '0; wait_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ale && psen_n && rd_n && wr_n, "R1 strobes idle", {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(!ad_oe && !ack, "R1 bus released, no ack", {ad_oe, ack}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    issue(2'b00, 20'h0_1234, 4'h0, 8'h00, 0);   // R2 internal fetch
    issue(2'b00, 20'hF_FFFF, 4'h0, 8'h00, 0);   // R2 internal boundary: upper address is external
    issue(2'b00, 20'h3_4567, 4'h0, 8'h00, 0);   // R3 external fetch, upper segment
    issue(2'b00, 20'h1_0000, 4'h0, 8'h00, 0);   // R3 first external address
    issue(2'b01, 20'h0_89AB, 4'h7, 8'h00, 0);   // R4/R7 data read, pc bits on top pins
    issue(2'b10, 20'h0_CDEF, 4'hA, 8'h96, 0);   // R4/R9 data write
    ea_int_en = 1'b0;
    issue(2'b00, 20'h0_0ABC, 4'h0, 8'h00, 0);   // R3 enable low: low fetch external
    issue(2'b01, 20'h5_1122, 4'hC, 8'h00, 3);   // R10 read with 3 wait ticks
    issue(2'b10, 20'h0_3344, 4'h1, 8'h5A, 1);   // R10 write with 1 wait tick
    issue(2'b00, 20'h2_5566, 4'h0, 8'h00, 4);   // R11 wait held during fetch
    ea_int_en = 1'b1;
    issue(2'b01, 20'h0_FF00, 4'hF, 8'h00, 0);   // R4 read in low segment still external
    issue(2'b00, 20'h0_FFFF, 4'h0, 8'h00, 0);   // R2 last internal address
    issue(2'b10, 20'h0_0001, 4'h0, 8'hFF, 2);   // R9/R10 write with wait

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule